// File: doc/BRIEF.md
# Auto-Zero and Calibration Conversion Sequencer

This block runs the conversion cycle of a voltage-to-frequency (V/F) based analog-to-digital front end. A cycle has two parts. The first is an error-correction segment made of three phases: a first zero phase, a full-scale calibration phase and a second zero phase. The second is a signal-measurement window. In each phase the block drives the input multiplexer select, the buffer gain select, the full-scale reference choice, the enables for the zero and calibration feedback loops, and three storage-switch controls. Each switch holds a correction voltage on its own capacitor.

During the measurement window the block counts rising edges of the V/F output. The pulse input first passes through a synchronizer and an edge detector. When the window closes, the next cycle starts on the same clock. In that clock the count is latched onto the result port and a one-clock valid strobe is raised. Time runs on a one-clock millisecond tick, so every phase length is a number of ticks. Cycles follow each other with no gap once the first tick after reset has started the sequence.

Top module: `azcal_conv_seq`

## Requirements
- R1: During reset and after it, before the first tick, the block is idle. In the idle state mux_sel is 0, every loop enable and storage switch is low, gain_x10 and fs_ref_low are low, and result_count and result_valid are 0. Asserting reset at any time returns the block to this state.
- R2: The first conversion cycle starts on the first ms_tick after reset. The phases run in the order first zero, calibration, second zero, measurement, and they last PH1_TICKS, CAL_TICKS, PH2_TICKS and MEAS_TICKS ticks (defaults 40/40/40/200). The phase changes only on a clock where ms_tick is high.
- R3: In the first zero phase, mux_sel is 0 (zero reference), az_loop_en is 1, zero_hold1 is 1, and gain_x10 equals the correction-gain bit.
- R4: In the calibration phase, mux_sel is 1 (full-scale reference), cal_loop_en is 1, span_hold is 1, and gain_x10 equals the correction-gain bit. fs_ref_low is 1 (low full-scale reference) exactly when that gain is 10x.
- R5: In the second zero phase, mux_sel is 0, az_loop_en is 1, zero_hold2 is 1, zero_hold1 is 0, and gain_x10 equals the measurement-gain bit.
- R6: In the measurement phase, mux_sel is 2 (signal input), all loop enables and switches are low, gain_x10 equals the measurement-gain bit, and every rising edge of vf_pulse adds one to the count.
- R7: Rising edges of vf_pulse during the correction phases do not change the result.
- R8: On the clock where the measurement phase ends, the next cycle's first zero phase begins. In that clock result_count shows the count and result_valid is high. result_valid stays high for that clock only.
- R9: The count saturates at 2^CNT_W-1 and does not wrap.
- R10: gain_req is sampled only when a cycle starts. Bit 0 selects 10x gain for the first zero and calibration phases, and bit 1 selects 10x gain for the second zero and measurement phases. A change made during a cycle takes effect at the next cycle.
- R11: At most one of zero_hold1, span_hold and zero_hold2 is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-clock millisecond timing tick |
| gain_req | input | 2 | Gain request: bit 0 correction gain, bit 1 measurement gain (1 = 10x) |
| vf_pulse | input | 1 | Asynchronous V/F converter output |
| mux_sel | output | 2 | Input select: 0 zero ref, 1 full-scale ref, 2 signal |
| gain_x10 | output | 1 | Buffer gain select, 1 = 10x |
| fs_ref_low | output | 1 | Selects the low full-scale reference during calibration |
| az_loop_en | output | 1 | Zero-correction loop enable |
| cal_loop_en | output | 1 | Scale-correction loop enable |
| zero_hold1 | output | 1 | First zero storage switch closed |
| span_hold | output | 1 | Calibration storage switch closed |
| zero_hold2 | output | 1 | Second zero storage switch closed |
| result_count | output | CNT_W | Latched pulse count of the last measurement |
| result_valid | output | 1 | One-clock strobe with a new result |

## Verification
A wrong phase or tick-count state shows at the ports right away. Either mux_sel and the switch pattern fail to match the expected phase on the next sampled clock, or a phase runs for a different number of clocks than its length times the tick spacing. A wrong latched gain is visible as soon as the following phase starts, because gain_x10 and fs_ref_low follow it. A fault in the pulse path or the counter stays hidden until the end of the measurement window. It then appears in result_count, so the bench sends a known number of edges in each window and also sends edges in the correction phases that must not be counted.

// File: rtl/azcal_pkg.sv
package azcal_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ZERO1 = 3'd1,
      PH_SPAN = 3'd2,
      PH_ZERO2 = 3'd3,
      PH_MEAS = 3'd4
   } phase_e;

   localparam logic [1:0] SEL_ZERO = 2'd0;
   localparam logic [1:0] SEL_FULL = 2'd1;
   localparam logic [1:0] SEL_SIG  = 2'd2;
endpackage

// File: rtl/azcal_pulse_sync.sv
module azcal_pulse_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("azcal_pulse_sync: STAGES must be at least 2");
   end

   // STAGES synchronizer flops plus one delay flop for edge detection
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], pulse_i};
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/azcal_phase_ctrl.sv
module azcal_phase_ctrl
   import azcal_pkg::*;
#(
   parameter int PH1_TICKS  = 40,
   parameter int CAL_TICKS  = 40,
   parameter int PH2_TICKS  = 40,
   parameter int MEAS_TICKS = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ms_tick,
   input  logic [1:0] gain_req,
   output phase_e     phase_o,
   output logic       meas_start_o,
   output logic       cycle_done_o,
   output logic [1:0] mux_sel_o,
   output logic       gain_x10_o,
   output logic       fs_ref_low_o,
   output logic       az_loop_en_o,
   output logic       cal_loop_en_o,
   output logic       zero_hold1_o,
   output logic       span_hold_o,
   output logic       zero_hold2_o
);
   localparam int MAX_A   = (PH1_TICKS > CAL_TICKS) ? PH1_TICKS : CAL_TICKS;
   localparam int MAX_B   = (PH2_TICKS > MEAS_TICKS) ? PH2_TICKS : MEAS_TICKS;
   localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TW      = $clog2(MAX_LEN + 1);
   localparam logic [TW-1:0] LAST_PH1  = TW'(PH1_TICKS - 1);
   localparam logic [TW-1:0] LAST_CAL  = TW'(CAL_TICKS - 1);
   localparam logic [TW-1:0] LAST_PH2  = TW'(PH2_TICKS - 1);
   localparam logic [TW-1:0] LAST_MEAS = TW'(MEAS_TICKS - 1);

   if (PH1_TICKS < 1 || CAL_TICKS < 1 || PH2_TICKS < 1 || MEAS_TICKS < 1) begin : g_bad_len
      $error("azcal_phase_ctrl: every phase length must be at least one tick");
   end

   phase_e          phase_q, phase_nxt;
   logic [TW-1:0]   tcnt_q;
   logic [TW-1:0]   last_val;
   logic            advance;
   logic            gain_cal_q, gain_meas_q;

   always_comb begin
      unique case (phase_q)
         PH_ZERO1: last_val = LAST_PH1;
         PH_SPAN:  last_val = LAST_CAL;
         PH_ZERO2: last_val = LAST_PH2;
         PH_MEAS:  last_val = LAST_MEAS;
         default:  last_val = '0;
      endcase
   end

   always_comb begin
      unique case (phase_q)
         PH_ZERO1: phase_nxt = PH_SPAN;
         PH_SPAN:  phase_nxt = PH_ZERO2;
         PH_ZERO2: phase_nxt = PH_MEAS;
         default:  phase_nxt = PH_ZERO1;   // idle and measurement both start a cycle
      endcase
   end

   assign advance      = ms_tick && (phase_q == PH_IDLE || tcnt_q == last_val);
   assign meas_start_o = advance && (phase_q == PH_ZERO2);
   assign cycle_done_o = advance && (phase_q == PH_MEAS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         tcnt_q      <= '0;
         gain_cal_q  <= 1'b0;
         gain_meas_q <= 1'b0;
      end else if (advance) begin
         phase_q <= phase_nxt;
         tcnt_q  <= '0;
         if (phase_nxt == PH_ZERO1) begin
            gain_cal_q  <= gain_req[0];
            gain_meas_q <= gain_req[1];
         end
      end else if (ms_tick && phase_q != PH_IDLE) begin
         tcnt_q <= tcnt_q + 1'b1;
      end
   end

   always_comb begin
      mux_sel_o     = SEL_ZERO;
      gain_x10_o    = 1'b0;
      fs_ref_low_o  = 1'b0;
      az_loop_en_o  = 1'b0;
      cal_loop_en_o = 1'b0;
      zero_hold1_o  = 1'b0;
      span_hold_o   = 1'b0;
      zero_hold2_o  = 1'b0;
      unique case (phase_q)
         PH_ZERO1: begin
            gain_x10_o   = gain_cal_q;
            az_loop_en_o = 1'b1;
            zero_hold1_o = 1'b1;
         end
         PH_SPAN: begin
            mux_sel_o     = SEL_FULL;
            gain_x10_o    = gain_cal_q;
            fs_ref_low_o  = gain_cal_q;
            cal_loop_en_o = 1'b1;
            span_hold_o   = 1'b1;
         end
         PH_ZERO2: begin
            gain_x10_o   = gain_meas_q;
            az_loop_en_o = 1'b1;
            zero_hold2_o = 1'b1;
         end
         PH_MEAS: begin
            mux_sel_o  = SEL_SIG;
            gain_x10_o = gain_meas_q;
         end
         default: ;
      endcase
   end

   assign phase_o = phase_q;

   // R2: the phase moves only on a tick
   assert_tick_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_tick |=> $stable(phase_q));
   // R10: latched gains hold through the correction phases
   assert_gain_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SPAN || phase_q == PH_ZERO2 || phase_q == PH_ZERO1 && !ms_tick)
      |=> $stable(gain_cal_q) && $stable(gain_meas_q));
endmodule

// File: rtl/azcal_pulse_counter.sv
module azcal_pulse_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             meas_i,
   input  logic             clear_i,
   input  logic             done_i,
   output logic [CNT_W-1:0] result_o,
   output logic             valid_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2) begin : g_bad_width
      $error("azcal_pulse_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         result_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (clear_i)
            cnt_q <= '0;
         else if (rise_i && meas_i && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
         if (done_i) begin
            result_o <= cnt_q;
            valid_o  <= 1'b1;
         end
      end
   end

   // R9: a full counter stays full
   assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !clear_i) |=> cnt_q == CNT_MAX);
   // R7: no counting outside the measurement window
   assert_no_count_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!meas_i && !clear_i) |=> $stable(cnt_q));
   // R8: valid strobe lasts one clock
   assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
endmodule

// File: rtl/azcal_conv_seq.sv
module azcal_conv_seq
   import azcal_pkg::*;
#(
   parameter int CNT_W       = 20,
   parameter int SYNC_STAGES = 2,
   parameter int PH1_TICKS   = 40,
   parameter int CAL_TICKS   = 40,
   parameter int PH2_TICKS   = 40,
   parameter int MEAS_TICKS  = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic [1:0]       gain_req,
   input  logic             vf_pulse,
   output logic [1:0]       mux_sel,
   output logic             gain_x10,
   output logic             fs_ref_low,
   output logic             az_loop_en,
   output logic             cal_loop_en,
   output logic             zero_hold1,
   output logic             span_hold,
   output logic             zero_hold2,
   output logic [CNT_W-1:0] result_count,
   output logic             result_valid
);
   phase_e phase;
   logic   meas_start, cycle_done, vf_rise;

   azcal_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_i (vf_pulse),
      .rise_o  (vf_rise)
   );

   azcal_phase_ctrl #(
      .PH1_TICKS  (PH1_TICKS),
      .CAL_TICKS  (CAL_TICKS),
      .PH2_TICKS  (PH2_TICKS),
      .MEAS_TICKS (MEAS_TICKS)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .ms_tick       (ms_tick),
      .gain_req      (gain_req),
      .phase_o       (phase),
      .meas_start_o  (meas_start),
      .cycle_done_o  (cycle_done),
      .mux_sel_o     (mux_sel),
      .gain_x10_o    (gain_x10),
      .fs_ref_low_o  (fs_ref_low),
      .az_loop_en_o  (az_loop_en),
      .cal_loop_en_o (cal_loop_en),
      .zero_hold1_o  (zero_hold1),
      .span_hold_o   (span_hold),
      .zero_hold2_o  (zero_hold2)
   );

   azcal_pulse_counter #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (vf_rise),
      .meas_i   (phase == PH_MEAS),
      .clear_i  (meas_start),
      .done_i   (cycle_done),
      .result_o (result_count),
      .valid_o  (result_valid)
   );

   // R11: never two storage switches closed together
   assert_one_switch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({zero_hold1, span_hold, zero_hold2}));
   // R6: the signal input is never selected while a switch is closed
   assert_sig_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_hold1 || span_hold || zero_hold2) |-> mux_sel != SEL_SIG);
   // R8: a result strobe always coincides with the start of a first zero phase
   assert_valid_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> zero_hold1);
endmodule

// File: tb/azcal_conv_seq_tb_top.sv
module azcal_conv_seq_tb_top;
   localparam int CW   = 6;
   localparam int TDIV = 8;
   localparam int LP1 = 3, LCAL = 3, LP2 = 3, LMEAS = 40;
   localparam int NV = 6;
   // entry: {gain_req[1:0], pulses[6:0], expected[6:0]}
   localparam logic [15:0] VEC [NV] = '{
      {2'b00, 7'd0,  7'd0},
      {2'b01, 7'd5,  7'd5},
      {2'b10, 7'd17, 7'd17},
      {2'b11, 7'd63, 7'd63},
      {2'b00, 7'd70, 7'd63},
      {2'b01, 7'd1,  7'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0;
   logic [1:0] gain_req = 2'b00;
   logic vf_pulse = 1'b0;
   logic tick_en = 1'b0;
   logic [2:0] tdiv = '0;
   logic [1:0] mux_sel;
   logic gain_x10, fs_ref_low, az_loop_en, cal_loop_en;
   logic zero_hold1, span_hold, zero_hold2, result_valid;
   logic [CW-1:0] result_count;
   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (!tick_en) begin
         tdiv <= '0;
         ms_tick <= 1'b0;
      end else begin
         ms_tick <= (tdiv == 3'(TDIV - 1));
         tdiv <= tdiv + 1'b1;
      end
   end

   azcal_conv_seq #(
      .CNT_W(CW), .SYNC_STAGES(2),
      .PH1_TICKS(LP1), .CAL_TICKS(LCAL), .PH2_TICKS(LP2), .MEAS_TICKS(LMEAS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .gain_req(gain_req),
      .vf_pulse(vf_pulse), .mux_sel(mux_sel), .gain_x10(gain_x10),
      .fs_ref_low(fs_ref_low), .az_loop_en(az_loop_en), .cal_loop_en(cal_loop_en),
      .zero_hold1(zero_hold1), .span_hold(span_hold), .zero_hold2(zero_hold2),
      .result_count(result_count), .result_valid(result_valid)
   );

   task automatic check(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic check_idle(input string req);
      check(req, {30'd0, mux_sel}, 0);
      check(req, {az_loop_en, cal_loop_en, zero_hold1, span_hold, zero_hold2}, 0);
      check(req, {gain_x10, fs_ref_low, result_valid}, 0);
      check(req, int'(result_count), 0);
   endtask

   task automatic run_vec(input logic [1:0] g, input int npulse, input int expc,
                          input logic [1:0] g_next);
      int k;
      while (!zero_hold1) @(negedge clk);
      // R3 first zero phase
      check("R3 mux", int'(mux_sel), 0);
      check("R3 loops", {az_loop_en, cal_loop_en, zero_hold2}, 3'b100);
      check("R3 gain", int'(gain_x10), int'(g[0]));
      k = 0;
      while (zero_hold1) begin
         if (k == 1) check("R8 valid one clock", int'(result_valid), 0);
         vf_pulse = k[1];   // R7 edges during correction
         k++;
         @(negedge clk);
      end
      vf_pulse = 1'b0;
      check("R2 zero1 length", k, LP1 * TDIV);
      // R4 calibration phase
      check("R4 mux", int'(mux_sel), 1);
      check("R4 loops", {az_loop_en, cal_loop_en, span_hold}, 3'b011);
      check("R4 gain", int'(gain_x10), int'(g[0]));
      check("R4 ref", int'(fs_ref_low), int'(g[0]));
      gain_req = ~g;   // R10 mid-cycle change
      k = 0;
      while (span_hold) begin k++; @(negedge clk); end
      check("R2 span length", k, LCAL * TDIV);
      // R5 second zero phase
      check("R5 mux", int'(mux_sel), 0);
      check("R5 switches", {az_loop_en, zero_hold1, zero_hold2}, 3'b101);
      check("R10 gain zero2", int'(gain_x10), int'(g[1]));
      k = 0;
      while (zero_hold2) begin k++; @(negedge clk); end
      check("R2 zero2 length", k, LP2 * TDIV);
      // R6 measurement
      check("R6 mux", int'(mux_sel), 2);
      check("R6 quiet", {az_loop_en, cal_loop_en, zero_hold1, span_hold, zero_hold2}, 0);
      check("R10 gain meas", int'(gain_x10), int'(g[1]));
      gain_req = g_next;
      k = 0;
      while (mux_sel == 2'd2) begin
         vf_pulse = (k >= 8 && k < 8 + 4 * npulse) ? (((k - 8) % 4) >= 2) : 1'b0;
         k++;
         @(negedge clk);
      end
      vf_pulse = 1'b0;
      check("R2 meas length", k, LMEAS * TDIV);
      check("R8 valid", int'(result_valid), 1);
      check("R8 restart", int'(zero_hold1), 1);
      check("R6 R9 count", int'(result_count), expc);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      gain_req = VEC[0][15:14];
      repeat (3) @(negedge clk);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check_idle("R1 R2 idle without tick");
      tick_en = 1'b1;
      for (int i = 0; i < NV; i++) begin
         logic [1:0] gn;
         gn = (i + 1 < NV) ? VEC[i + 1][15:14] : 2'b00;
         run_vec(VEC[i][15:14], int'(VEC[i][13:7]), int'(VEC[i][6:0]), gn);
      end
      // directed: reset in the middle of a measurement window
      while (mux_sel != 2'd2) @(negedge clk);
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R1 reset mid-cycle");
      rst_n = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule